// File: doc/BRIEF.md
# Serial Zero-Padded CRC Generator and Checker

This block computes a cyclic redundancy check over a serial bit stream, one bit per clock. It uses the augmented shift-register form. Each accepted bit enters the low end of a W-bit register, and every bit already there moves one place toward the top. When the bit pushed out of the top is a one, the register is XORed with the stored generator. The generator has W+1 bits, but its leading one is implicit, so only the low W bits are held in a parameter. By default W is 4 and the full generator is 10011.

In generate mode, the user marks the end of the message with a single-cycle pulse. The block then feeds W zero bits into the register by itself, raises a one-cycle done strobe, and leaves the CRC in the register.

In check mode, the received message is followed directly by its CRC, with no padding. On the end pulse, done rises on the next clock. A zero flag then shows whether the register came back to all zeros.

A synchronous clear empties the register before each message.

Top module: `crc_aug_serial`

## Requirements
- R1: After reset or a clear, `crc_out` is all zeros, `done` is 0 and `crc_ok` is 1.
- R2: On each clock edge with `bit_valid` high outside the padding phase, the register moves one place toward its top and `bit_in` enters bit 0. If the old top bit was 1, the result is XORed with the parameter `GEN`, which holds the low W bits of the generator. The defaults are W=4 and GEN=4'b0011, which is generator 10011.
- R3: In generate mode (`mode`=0), `msg_end` sampled outside padding starts W zero-bit shifts. `done` is then high for exactly one cycle, W clock edges after the edge that sampled `msg_end`. `crc_out` then holds the CRC: message 0110111, sent first bit first, gives 0110.
- R4: During the padding phase, `bit_valid`, `bit_in` and `msg_end` are ignored, so the resulting CRC and the timing of `done` do not change.
- R5: In check mode (`mode`=1), `msg_end` raises `done` on the next edge, with no padding. `crc_ok` is 1 exactly when `crc_out` is all zeros. Feeding 01101110110 gives `crc_ok`=1, and a corrupted final bit gives `crc_ok`=0.
- R6: `clear` has priority. A clear on the same edge as `bit_valid` or `msg_end` zeroes the register, and neither input takes effect.
- R7: Zero bits fed into a cleared register before a message leave its CRC unchanged.
- R8: A `msg_end` pulse may arrive together with the final `bit_valid`. That bit is included before padding starts.
- R9: With no `bit_valid` and no padding, `crc_out` holds its value, including the result after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of register and sequencing |
| mode | input | 1 | 0 = generate with padding, 1 = check without padding |
| bit_valid | input | 1 | Accept `bit_in` on this edge |
| bit_in | input | 1 | Serial data bit |
| msg_end | input | 1 | One-cycle end-of-message marker |
| done | output | 1 | One-cycle completion strobe |
| crc_out | output | W | Register contents: the CRC or the check remainder |
| crc_ok | output | 1 | High when the register is all zeros |

## Verification
The bench drives the short reference message in generate mode and the same message with its CRC in check mode. Together these confirm the shift direction and the final value.

Walking a single one through the register shows whether the generator XOR fires on the bit shifted out or on the wrong bit. Longer patterns, including all ones and sparse ones, are compared against a long-division model. Those patterns are then re-checked with their CRC appended and with a flipped bit, which separates a passing check from a failing one.

Further runs cover the following cases:
- leading zeros;
- an end marker that arrives with the last bit;
- junk inputs during padding;
- a clear that collides with data.

These show whether the padding phase and the priority of clear are exact.

// File: rtl/crc_aug_pkg.sv
package crc_aug_pkg;

  localparam int unsigned MAX_W = 32;
  typedef logic [MAX_W-1:0] crc_word_t;

  localparam logic MODE_GEN = 1'b0;
  localparam logic MODE_CHK = 1'b1;

  // Ones in the low w positions
  function automatic crc_word_t width_mask(int unsigned w);
    if (w >= MAX_W) return '1;
    return (crc_word_t'(1) << w) - crc_word_t'(1);
  endfunction

  // One serial step: shift in b at bit 0, fold generator if top bit left
  function automatic crc_word_t crc_bit_step(crc_word_t r, logic b,
                                             crc_word_t g, int unsigned w);
    crc_word_t nxt;
    logic      top;
    top = |(r & (crc_word_t'(1) << (w - 1)));
    nxt = ((r << 1) | crc_word_t'(b)) & width_mask(w);
    if (top) nxt = nxt ^ (g & width_mask(w));
    return nxt;
  endfunction

endpackage

// File: rtl/crc_aug_shreg.sv
module crc_aug_shreg
  import crc_aug_pkg::*;
#(
  parameter int unsigned    W   = 4,
  parameter logic [W-1:0]   GEN = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] crc_q
);

  crc_word_t step_w;

  assign step_w = crc_bit_step(crc_word_t'(crc_q), shift_bit,
                               crc_word_t'(GEN), W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= '0;
    else if (clear)     crc_q <= '0;
    else if (shift_en)  crc_q <= step_w[W-1:0];
  end

endmodule

// File: rtl/crc_aug_pad_ctrl.sv
module crc_aug_pad_ctrl
  import crc_aug_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic mode,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic msg_end,
  output logic shift_en,
  output logic shift_bit,
  output logic pad_active,
  output logic done
);

  localparam int unsigned       CNT_W    = $clog2(W + 1);
  localparam logic [CNT_W-1:0]  LAST_PAD = CNT_W'(W - 1);

  logic [CNT_W-1:0] pad_cnt;
  logic             pad_last;
  logic             start_pad;
  logic             end_chk;

  assign pad_last  = pad_active && (pad_cnt == LAST_PAD);
  assign start_pad = !clear && !pad_active && msg_end && (mode == MODE_GEN);
  assign end_chk   = !clear && !pad_active && msg_end && (mode == MODE_CHK);

  always_comb begin
    shift_en  = 1'b0;
    shift_bit = 1'b0;
    if (!clear) begin
      if (pad_active) begin
        shift_en  = 1'b1;
        shift_bit = 1'b0;
      end else begin
        shift_en  = bit_valid;
        shift_bit = bit_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_active <= 1'b0;
      pad_cnt    <= '0;
      done       <= 1'b0;
    end else if (clear) begin
      pad_active <= 1'b0;
      pad_cnt    <= '0;
      done       <= 1'b0;
    end else begin
      done <= pad_last || end_chk;
      if (pad_active) begin
        pad_cnt <= pad_cnt + 1'b1;
        if (pad_last) begin
          pad_active <= 1'b0;
          pad_cnt    <= '0;
        end
      end else if (start_pad) begin
        pad_active <= 1'b1;
        pad_cnt    <= '0;
      end
    end
  end

endmodule

// File: rtl/crc_aug_serial.sv
module crc_aug_serial
  import crc_aug_pkg::*;
#(
  parameter int unsigned  W   = 4,
  parameter logic [W-1:0] GEN = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         mode,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         msg_end,
  output logic         done,
  output logic [W-1:0] crc_out,
  output logic         crc_ok
);

  logic shift_en;
  logic shift_bit;
  logic pad_active;

  crc_aug_pad_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .mode       (mode),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .msg_end    (msg_end),
    .shift_en   (shift_en),
    .shift_bit  (shift_bit),
    .pad_active (pad_active),
    .done       (done)
  );

  crc_aug_shreg #(.W(W), .GEN(GEN)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .crc_q     (crc_out)
  );

  assign crc_ok = (crc_out == '0);

endmodule

// File: rtl/crc_aug_serial_chk.sv
module crc_aug_serial_chk
  import crc_aug_pkg::*;
#(
  parameter int unsigned  W   = 4,
  parameter logic [W-1:0] GEN = 4'b0011
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         mode,
  input logic         bit_valid,
  input logic         msg_end,
  input logic         done,
  input logic [W-1:0] crc_out,
  input logic         pad_active
);

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == '0 && !done && !pad_active));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pad_active && !bit_valid) |=> $stable(crc_out));

  a_r4_pad_feeds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_active && !clear) |=>
      (crc_word_t'(crc_out) ==
       crc_bit_step(crc_word_t'($past(crc_out)), 1'b0, crc_word_t'(GEN), W)));

  a_r3_pad_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pad_active && msg_end && mode == MODE_GEN) |=> pad_active);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(msg_end && mode == MODE_CHK && !clear && !pad_active))
      |=> !done);

  a_r5_check_no_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pad_active && msg_end && mode == MODE_CHK)
      |=> (done && !pad_active));

endmodule

bind crc_aug_serial crc_aug_serial_chk #(.W(W), .GEN(GEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .mode       (mode),
  .bit_valid  (bit_valid),
  .msg_end    (msg_end),
  .done       (done),
  .crc_out    (crc_out),
  .pad_active (pad_active)
);

// File: tb/crc_aug_serial_test.sv
`timescale 1ns/1ps
module crc_aug_serial_test;

  localparam int unsigned W = 4;
  localparam logic [W-1:0] GEN = 4'b0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, mode = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, msg_end = 1'b0;
  logic done, crc_ok;
  logic [W-1:0] crc_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc_aug_serial #(.W(W), .GEN(GEN)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode),
    .bit_valid(bit_valid), .bit_in(bit_in), .msg_end(msg_end),
    .done(done), .crc_out(crc_out), .crc_ok(crc_ok)
  );

  // Long division remainder with full W+1 bit divisor, first bit = bits[n-1]
  function automatic logic [W-1:0] ref_rem(logic [63:0] bits, int n);
    logic [W:0] acc = '0;
    for (int i = n - 1; i >= 0; i--) begin
      acc = {acc[W-1:0], bits[i]};
      if (acc[W]) acc = acc ^ {1'b1, GEN};
    end
    return acc[W-1:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic feed_bits(logic [63:0] bits, int n, bit end_on_last);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1; bit_in = bits[i];
      msg_end = end_on_last && (i == 0);
    end
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0; msg_end = 1'b0;
  endtask

  task automatic end_msg();
    @(negedge clk); msg_end = 1'b1;
    @(negedge clk); msg_end = 1'b0;
  endtask

  // Called at the negedge just after the edge that sampled msg_end
  task automatic wait_done(bit junk, output int k);
    k = 1;
    while (!done && k < 20) begin
      if (junk) begin bit_valid = 1'b1; bit_in = 1'b1; msg_end = 1'b1; end
      @(negedge clk);
      k++;
    end
    bit_valid = 1'b0; bit_in = 1'b0; msg_end = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset crc_out", 32'(crc_out), 0);
    check("R1 reset done", 32'(done), 0);
    check("R1 reset crc_ok", 32'(crc_ok), 1);
  endtask

  task automatic t_step_rule();
    logic [63:0] b = 64'b10000;
    mode = 1'b0; do_clear();
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = b[i];
      @(negedge clk); bit_valid = 1'b0;
      check("R2 step", 32'(crc_out), 32'(ref_rem(b >> i, 5 - i)));
    end
    check("R2 xor fired", 32'(crc_out), 32'h3);
  endtask

  task automatic t_gen(string tag, logic [63:0] msg, int n, bit end_on_last,
                       bit junk, logic [W-1:0] exp);
    int k;
    mode = 1'b0; do_clear();
    feed_bits(msg, n, end_on_last);
    if (!end_on_last) end_msg();
    wait_done(junk, k);
    check({tag, " done timing"}, 32'(k), W + 1);
    check({tag, " crc"}, 32'(crc_out), 32'(exp));
    @(negedge clk);
    check("R3 done one cycle", 32'(done), 0);
    repeat (4) @(negedge clk);
    check("R9 result held", 32'(crc_out), 32'(exp));
  endtask

  task automatic t_chk(string tag, logic [63:0] bits, int n, bit exp_ok);
    int k;
    mode = 1'b1; do_clear();
    feed_bits(bits, n, 1'b0);
    end_msg();
    wait_done(1'b0, k);
    check({tag, " done timing"}, 32'(k), 1);
    check({tag, " crc_ok"}, 32'(crc_ok), 32'(exp_ok));
    check({tag, " remainder"}, 32'(crc_out), 32'(ref_rem(bits, n)));
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 0);
    mode = 1'b0;
  endtask

  task automatic t_clear_prio();
    mode = 1'b0; do_clear();
    feed_bits(64'b101, 3, 1'b0);
    @(negedge clk);
    clear = 1'b1; bit_valid = 1'b1; bit_in = 1'b1; msg_end = 1'b1;
    @(negedge clk);
    clear = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; msg_end = 1'b0;
    check("R6 clear wins over bit", 32'(crc_out), 0);
    check("R6 clear done", 32'(done), 0);
    for (int i = 0; i < W + 2; i++) begin
      @(negedge clk);
      check("R6 no pad started", 32'(done), 0);
    end
  endtask

  task automatic t_long(logic [15:0] m);
    logic [W-1:0] c;
    c = ref_rem({44'b0, m, 4'b0}, 20);
    t_gen("R2 long pattern", {48'b0, m}, 16, 1'b0, 1'b0, c);
    t_chk("R5 long good", {44'b0, m, c}, 20, 1'b1);
    t_chk("R5 long flipped", {44'b0, m, c} ^ 64'h100, 20, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_rule();
    t_gen("R3 gen 0110111", 64'b0110111, 7, 1'b0, 1'b0, 4'b0110);
    t_chk("R5 check good", 64'b01101110110, 11, 1'b1);
    t_chk("R5 check bad", 64'b01101110111, 11, 1'b0);
    t_gen("R7 leading zeros", 64'b0000110111, 10, 1'b0, 1'b0, 4'b0110);
    t_gen("R8 end with last bit", 64'b0110111, 7, 1'b1, 1'b0, 4'b0110);
    t_gen("R4 junk in padding", 64'b0110111, 7, 1'b0, 1'b1, 4'b0110);
    t_clear_prio();
    do_clear();
    t_reset();
    t_long(16'hB5C3);
    t_long(16'hFFFF);
    t_long(16'h8001);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(1_000_000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule